// File: doc/BRIEF.md
# Pulse Counter with Auxiliary Counter

This block counts edges on a single count input. Each edge of the chosen polarity becomes one event, and that event is an up event or a down event. Two counters accumulate these events. The main counter can move in both directions. The auxiliary counter only ever moves upward. A 2-bit event selector for each counter decides which kind of event the counter responds to.

The count direction comes from one of two places. One is a control bit. The other is the level of a second input, chosen when the pin-direction enable is set. The block runs in one clock domain. The count input is assumed to be already synchronised, and each edge is found by comparing the input with a registered copy of itself. A synchronous clear zeroes both counters.

Top module: `event_tally`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), both `main_count` and `aux_count` read 0, and the registered copy of the count input is 0.
- R2: When `run_mode` is 0 (off) or 3 (reserved), no events occur and both counters hold their values.
- R3: When `run_mode` is 1 or 2, each count-input edge of the selected polarity produces exactly one event. With `edge_fall`=0 the polarity is rising (0 to 1); with `edge_fall`=1 it is falling (1 to 0). The counters change at the first clock edge at which `cnt_in` differs from its registered copy.
- R4: With `dir_from_pin`=0, an event is an up event when `dir_bit`=0 and a down event when `dir_bit`=1. With `dir_from_pin`=1, the level of `dir_in` sampled at that clock edge decides instead (1 = down, 0 = up), and `dir_bit` has no effect.
- R5: With `main_sel`=0, the main counter increments by 1 on an up event and decrements by 1 on a down event.
- R6: With `main_sel`=1, the main counter increments on up events and holds on down events. With `main_sel`=2, it decrements on down events and holds on up events. With `main_sel`=3, it never changes except through clear.
- R7: The auxiliary counter increments by 1 on events chosen by `aux_sel`: 0 = none, 1 = up events, 2 = down events, 3 = both. It never decrements.
- R8: Both counters are 16 bits wide by default. The main counter wraps from 0 down to 0xFFFF and from 0xFFFF up to 0. The auxiliary counter wraps from 0xFFFF to 0.
- R9: `clr` high at a clock edge zeroes both counters. It takes priority over an event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | 1 | Count input, already synchronous to clk |
| dir_in | input | 1 | Direction input used when dir_from_pin is set (1 = down) |
| run_mode | input | 2 | 0 off, 1 sampled single input, 2 externally clocked single input, 3 reserved (no counting) |
| dir_bit | input | 1 | Direction control bit (1 = down) |
| edge_fall | input | 1 | 0 counts rising edges, 1 counts falling edges |
| dir_from_pin | input | 1 | 1 takes the direction from dir_in instead of dir_bit |
| main_sel | input | 2 | Main counter event select |
| aux_sel | input | 2 | Auxiliary counter event select |
| clr | input | 1 | Synchronous clear of both counters |
| main_count | output | 16 | Main counter value |
| aux_count | output | 16 | Auxiliary counter value |

## Verification
Two functions can fall in the same cycle: a clear and a count event. In the stimulus, `clr` is raised at the same clock edge at which a selected edge of `cnt_in` reaches the block. The outcome is judged by requiring both counters to read 0 afterwards, with no trace of the event. The next edge must then count from 0. A second pairing in one cycle is a change of `dir_in` alongside an edge, which checks that the direction is sampled with the edge and not one cycle later.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int DEFAULT_WIDTH = 16;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_SAMPLED = 2'd1,
        MODE_EXTCLK  = 2'd2,
        MODE_RSVD    = 2'd3
    } run_mode_e;

    typedef enum logic [1:0] {
        MSEL_BOTH = 2'd0,
        MSEL_UP   = 2'd1,
        MSEL_DOWN = 2'd2,
        MSEL_NONE = 2'd3
    } main_sel_e;

    typedef enum logic [1:0] {
        ASEL_NONE = 2'd0,
        ASEL_UP   = 2'd1,
        ASEL_DOWN = 2'd2,
        ASEL_BOTH = 2'd3
    } aux_sel_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    typedef struct packed {
        logic up;
        logic dn;
    } ev_t;

    function automatic logic mode_counts(run_mode_e m);
        return (m == MODE_SAMPLED) || (m == MODE_EXTCLK);
    endfunction

    function automatic step_e main_step(main_sel_e s, ev_t e);
        step_e r;
        r = STEP_HOLD;
        unique case (s)
            MSEL_BOTH: begin
                if (e.up) r = STEP_INC;
                else if (e.dn) r = STEP_DEC;
            end
            MSEL_UP:   if (e.up) r = STEP_INC;
            MSEL_DOWN: if (e.dn) r = STEP_DEC;
            default:   r = STEP_HOLD;
        endcase
        return r;
    endfunction

    function automatic logic aux_step(aux_sel_e s, ev_t e);
        logic r;
        unique case (s)
            ASEL_UP:   r = e.up;
            ASEL_DOWN: r = e.dn;
            ASEL_BOTH: r = e.up | e.dn;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/evt_edge_gen.sv
module evt_edge_gen
    import evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cnt_in,
    input  logic      dir_in,
    input  run_mode_e mode,
    input  logic      dir_bit,
    input  logic      edge_fall,
    input  logic      dir_from_pin,
    output ev_t       ev
);

    logic in_prev;
    logic edge_seen;
    logic go_down;

    always_ff @(posedge clk) begin
        if (rst) in_prev <= 1'b0;
        else     in_prev <= cnt_in;
    end

    always_comb begin
        if (edge_fall) edge_seen = in_prev & ~cnt_in;
        else           edge_seen = ~in_prev & cnt_in;
        go_down = dir_from_pin ? dir_in : dir_bit;
        ev.up   = mode_counts(mode) & edge_seen & ~go_down;
        ev.dn   = mode_counts(mode) & edge_seen & go_down;
    end

    // R3: an edge of fixed polarity cannot yield events on two cycles in a row
    assert_single_event_R3: assert property (@(posedge clk) disable iff (rst)
        (ev.up || ev.dn) |=> (!(ev.up || ev.dn) || (edge_fall != $past(edge_fall))));

endmodule

// File: rtl/evt_main_ctr.sv
module evt_main_ctr
    import evt_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  main_sel_e        sel,
    input  ev_t              ev,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    step_e step;

    always_comb step = main_step(sel, ev);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else begin
            unique case (step)
                STEP_INC: count <= count + ONE;
                STEP_DEC: count <= count - ONE;
                default:  count <= count;
            endcase
        end
    end

    // R9: a clear always leaves the counter at zero
    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

    // R6: the never-count selection freezes the value
    assert_none_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!clr && sel == MSEL_NONE) |=> $stable(count));

    // R5: an up event in both-direction selection adds exactly one
    assert_up_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!clr && ev.up && sel == MSEL_BOTH) |=> (count == $past(count) + ONE));

endmodule

// File: rtl/evt_aux_ctr.sv
module evt_aux_ctr
    import evt_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  aux_sel_e         sel,
    input  ev_t              ev,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic bump;

    always_comb bump = aux_step(sel, ev);

    always_ff @(posedge clk) begin
        if (rst || clr)  count <= '0;
        else if (bump)   count <= count + ONE;
    end

    // R7: without a clear the value either holds or moves up by one
    assert_no_decrement_R7: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((count == $past(count)) || (count == $past(count) + ONE)));

    // R9: clear zeroes the auxiliary value too
    assert_aux_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

endmodule

// File: rtl/event_tally.sv
module event_tally
    import evt_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_in,
    input  logic             dir_in,
    input  logic [1:0]       run_mode,
    input  logic             dir_bit,
    input  logic             edge_fall,
    input  logic             dir_from_pin,
    input  logic [1:0]       main_sel,
    input  logic [1:0]       aux_sel,
    input  logic             clr,
    output logic [WIDTH-1:0] main_count,
    output logic [WIDTH-1:0] aux_count
);

    ev_t ev;

    evt_edge_gen u_edge (
        .clk          (clk),
        .rst          (rst),
        .cnt_in       (cnt_in),
        .dir_in       (dir_in),
        .mode         (run_mode_e'(run_mode)),
        .dir_bit      (dir_bit),
        .edge_fall    (edge_fall),
        .dir_from_pin (dir_from_pin),
        .ev           (ev)
    );

    evt_main_ctr #(.WIDTH(WIDTH)) u_main (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .sel   (main_sel_e'(main_sel)),
        .ev    (ev),
        .count (main_count)
    );

    evt_aux_ctr #(.WIDTH(WIDTH)) u_aux (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .sel   (aux_sel_e'(aux_sel)),
        .ev    (ev),
        .count (aux_count)
    );

    // R2: off and reserved modes leave both counters untouched
    assert_idle_mode_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && (run_mode == 2'd0 || run_mode == 2'd3))
            |=> ($stable(main_count) && $stable(aux_count)));

endmodule

// File: tb/event_tally_bench.sv
module event_tally_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int WATCHDOG_CYCLES = 180000;

    typedef struct {
        logic       cnt_in;
        logic       dir_in;
        logic [1:0] run_mode;
        logic       dir_bit;
        logic       edge_fall;
        logic       dir_from_pin;
        logic [1:0] main_sel;
        logic [1:0] aux_sel;
        logic       clr;
    } cfg_t;

    typedef struct {
        logic [W-1:0] main_v;
        logic [W-1:0] aux_v;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    cfg_t cur;
    cfg_t nx;
    logic [W-1:0] main_count;
    logic [W-1:0] aux_count;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic         m_prev = 1'b0;
    logic [W-1:0] m_main = '0;
    logic [W-1:0] m_aux  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    event_tally #(.WIDTH(W)) u_event_tally (
        .clk          (clk),
        .rst          (rst),
        .cnt_in       (cur.cnt_in),
        .dir_in       (cur.dir_in),
        .run_mode     (cur.run_mode),
        .dir_bit      (cur.dir_bit),
        .edge_fall    (cur.edge_fall),
        .dir_from_pin (cur.dir_from_pin),
        .main_sel     (cur.main_sel),
        .aux_sel      (cur.aux_sel),
        .clr          (cur.clr),
        .main_count   (main_count),
        .aux_count    (aux_count)
    );

    // Expected-value model built from the requirements
    task automatic model_cycle();
        logic ev, down, up_e, dn_e;
        ev = 1'b0;
        if (cur.run_mode == 2'd1 || cur.run_mode == 2'd2)
            ev = cur.edge_fall ? (m_prev && !cur.cnt_in) : (!m_prev && cur.cnt_in);
        down = cur.dir_from_pin ? cur.dir_in : cur.dir_bit;
        up_e = ev && !down;
        dn_e = ev && down;
        if (cur.clr) begin
            m_main = '0;
            m_aux  = '0;
        end else begin
            case (cur.main_sel)
                2'd0: begin
                    if (up_e) m_main = m_main + 1'b1;
                    if (dn_e) m_main = m_main - 1'b1;
                end
                2'd1: if (up_e) m_main = m_main + 1'b1;
                2'd2: if (dn_e) m_main = m_main - 1'b1;
                default: ;
            endcase
            if ((cur.aux_sel[0] && up_e) || (cur.aux_sel[1] && dn_e))
                m_aux = m_aux + 1'b1;
        end
        m_prev = cur.cnt_in;
    endtask

    // Driver: apply the next configuration away from the active edge, push expectation
    task automatic step(input string tag, input logic in_val);
        exp_t e;
        @(negedge clk);
        nx.cnt_in = in_val;
        cur = nx;
        model_cycle();
        e.main_v = m_main;
        e.aux_v  = m_aux;
        e.tag    = tag;
        q.push_back(e);
    endtask

    task automatic pulse(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            step(tag, 1'b1);
            step(tag, 1'b0);
        end
    endtask

    // Monitor: compare one result after each active edge
    always @(posedge clk) begin
        #1;
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (main_count !== e.main_v || aux_count !== e.aux_v) begin
                errors++;
                $display("FAIL %s main=%h aux=%h expected main=%h aux=%h",
                         e.tag, main_count, aux_count, e.main_v, e.aux_v);
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired main=%h aux=%h expected completion", main_count, aux_count);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        nx = '{cnt_in: 1'b0, dir_in: 1'b0, run_mode: 2'd0, dir_bit: 1'b0, edge_fall: 1'b0,
               dir_from_pin: 1'b0, main_sel: 2'd0, aux_sel: 2'd0, clr: 1'b0};
        cur = nx;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        checks++;
        if (main_count !== '0 || aux_count !== '0) begin
            errors++;
            $display("FAIL R1 reset main=%h aux=%h expected 0000 0000", main_count, aux_count);
        end

        // R2: off and reserved modes
        nx.aux_sel = 2'd3;
        pulse("R2 off", 3);
        nx.run_mode = 2'd3;
        pulse("R2 reserved", 3);

        // R3 and R5: rising edges, up direction
        nx.run_mode = 2'd1;
        pulse("R3 rising up", 3);
        nx.edge_fall = 1'b1;
        pulse("R3 falling", 2);
        nx.edge_fall = 1'b0;
        // R4: control-bit down direction
        nx.dir_bit = 1'b1;
        pulse("R4 dir bit down", 2);
        // R4: pin direction, dir_bit ignored
        nx.dir_from_pin = 1'b1;
        nx.dir_in = 1'b0;
        pulse("R4 pin up", 2);
        nx.dir_in = 1'b1;
        nx.dir_bit = 1'b0;
        pulse("R4 pin down", 1);
        nx.dir_in = 1'b0;
        step("R4 pin changes with edge", 1'b1);
        step("R4 pin changes with edge", 1'b0);
        nx.dir_from_pin = 1'b0;

        // R6: main selectors
        nx.run_mode = 2'd2;
        nx.main_sel = 2'd1;
        nx.dir_bit = 1'b1;
        pulse("R6 up-only ignores down", 2);
        nx.dir_bit = 1'b0;
        pulse("R6 up-only counts up", 2);
        nx.main_sel = 2'd2;
        pulse("R6 down-only ignores up", 2);
        nx.dir_bit = 1'b1;
        pulse("R6 down-only counts down", 1);
        nx.main_sel = 2'd3;
        pulse("R6 never", 2);

        // R7: auxiliary selectors
        nx.main_sel = 2'd0;
        nx.aux_sel = 2'd0;
        pulse("R7 aux none", 2);
        nx.aux_sel = 2'd1;
        pulse("R7 aux up-sel with down", 2);
        nx.dir_bit = 1'b0;
        pulse("R7 aux up-sel with up", 2);
        nx.aux_sel = 2'd2;
        pulse("R7 aux down-sel with up", 2);
        nx.dir_bit = 1'b1;
        pulse("R7 aux down-sel with down", 2);

        // R9: clear coincident with an edge
        nx.aux_sel = 2'd3;
        nx.clr = 1'b1;
        step("R9 clear beats event", 1'b1);
        nx.clr = 1'b0;
        step("R9 after clear", 1'b0);
        pulse("R9 counting resumes", 1);

        // R8: main wraps both ways
        nx.clr = 1'b1;
        step("R8 prep", 1'b0);
        nx.clr = 1'b0;
        nx.aux_sel = 2'd0;
        nx.dir_bit = 1'b1;
        pulse("R8 main underflow", 1);
        nx.dir_bit = 1'b0;
        pulse("R8 main overflow", 1);
        // R8: auxiliary wraps after a full cycle of increments
        nx.main_sel = 2'd3;
        nx.aux_sel = 2'd1;
        pulse("R8 aux wrap", 1 << W);
        pulse("R8 aux after wrap", 1);

        repeat (3) @(posedge clk);
        #2;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule